// File: doc/BRIEF.md
# Ten-Bit Parallel-to-Serial Transmit Path with Loopback

This block turns a stream of already line-coded 10-bit words into a serial bit stream. It runs entirely on the bit-rate clock. An internal bit-phase counter divides that clock by the word width and drives a byte-clock output, `byte_clk_o`. A word presented on `tx_word_i` is captured at the bit-clock edge where `byte_clk_o` rises. It is then sent least significant bit first, one bit per bit clock, with no gap between consecutive words.

In normal operation the stream drives two mirrored serial outputs, `ser_a_o` and `ser_b_o`. When `loop_en_i` is raised, both external outputs are parked at logic 1 and the stream is sent instead on `wrap_o`, which feeds a receiver's input selector so the link can be tested without the medium. The block applies no line coding: every 10-bit pattern passes through unchanged.

Top module: `txser_top`

## Requirements
- R1: The 10-bit word on `tx_word_i` is captured at the bit-clock edge where `byte_clk_o` goes from 0 to 1. A word that changes at any other time, but is stable around that edge, is sent exactly as captured.
- R2: `byte_clk_o` has a period of 10 bit clocks and is high for 5 and low for 5. It is 1 during and right after reset, and its first rise after reset comes at the 10th rising bit-clock edge after reset is released.
- R3: The bits of each word leave in order from bit 0 (least significant) to bit 9 (most significant).
- R4: With `loop_en_i` low, `ser_a_o` and `ser_b_o` carry the same bit in every cycle.
- R5: With `loop_en_i` sampled high at a bit-clock edge, both `ser_a_o` and `ser_b_o` are 1 after that edge.
- R6: With `loop_en_i` sampled high at an edge, `wrap_o` carries the serial bit after that edge. With it sampled low, `wrap_o` is 1.
- R7: Bit 0 of a captured word appears on the outputs one bit clock after the capture edge, and bit k appears k+1 edges after it. Bit 0 of the next word follows bit 9 of the previous word with no idle cycle.
- R8: During reset, and after reset until bit 0 of the first captured word appears, `ser_a_o`, `ser_b_o` and `wrap_o` are 1.
- R9: No coding is applied: the all-zero word 0x000 and the all-one word 0x3FF are sent bit for bit like any other pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_word_i | input | 10 | Pre-coded parallel word, bit 0 sent first |
| loop_en_i | input | 1 | 1 diverts the stream to `wrap_o` and parks the external outputs at 1 |
| byte_clk_o | output | 1 | Divided byte clock; its rise marks the capture edge |
| ser_a_o | output | 1 | Serial output A |
| ser_b_o | output | 1 | Serial output B, a mirror of A |
| wrap_o | output | 1 | Internal loopback stream toward the receiver |

## Verification
Bit 0 of a word is due one edge after the rise of `byte_clk_o` that captured it, and bit k is due k+1 edges after that rise. A change on `loop_en_i` takes effect at the first edge that samples it. The bench synchronizes once to a rise of `byte_clk_o` and then counts posedges, sampling every output at the following falling edge. It drives the next word and any loopback change at the falling edge just after a capture, which keeps the inputs stable for the full byte period before the next capture. The idle and latency checks count edges from reset release and compare the output in each cycle up to the first bit with the required constant 1.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam int TXSER_WORD_W = 10;

  function automatic int phase_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/txser_phase.sv
module txser_phase
  import txser_pkg::*;
#(
  parameter int WORD_W = TXSER_WORD_W
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic load_o,
  output logic cap_o,
  output logic byte_clk_o
);
  localparam int PH_W = phase_bits(WORD_W);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(WORD_W - 1);
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(WORD_W / 2);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;

  always_comb begin
    if (ph_q == LAST_PH) ph_nxt = '0;
    else                 ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q       <= '0;
      byte_clk_o <= 1'b1;
    end else begin
      ph_q       <= ph_nxt;
      byte_clk_o <= (ph_nxt < HALF_PH);
    end
  end

  assign load_o = (ph_q == '0);
  assign cap_o  = (ph_q == LAST_PH);
endmodule

// File: rtl/txser_shift.sv
module txser_shift
  import txser_pkg::*;
#(
  parameter int WORD_W = TXSER_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cap_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q <= '1;
      sreg_q <= '1;
    end else begin
      if (cap_i) hold_q <= word_i;
      if (load_i) sreg_q <= {1'b1, hold_q[WORD_W-1:1]};
      else        sreg_q <= {1'b1, sreg_q[WORD_W-1:1]};
    end
  end

  assign bit_o = load_i ? hold_q[0] : sreg_q[0];
endmodule

// File: rtl/txser_outsel.sv
module txser_outsel (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_i,
  input  logic loop_i,
  output logic ser_a_o,
  output logic ser_b_o,
  output logic wrap_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ser_a_o <= 1'b1;
      ser_b_o <= 1'b1;
      wrap_o  <= 1'b1;
    end else begin
      ser_a_o <= loop_i ? 1'b1 : bit_i;
      ser_b_o <= loop_i ? 1'b1 : bit_i;
      wrap_o  <= loop_i ? bit_i : 1'b1;
    end
  end
endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter int WORD_W = TXSER_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              loop_en_i,
  output logic              byte_clk_o,
  output logic              ser_a_o,
  output logic              ser_b_o,
  output logic              wrap_o
);
  logic load_w;
  logic cap_w;
  logic bit_w;

  txser_phase #(.WORD_W(WORD_W)) phase_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_o     (load_w),
    .cap_o      (cap_w),
    .byte_clk_o (byte_clk_o)
  );

  txser_shift #(.WORD_W(WORD_W)) shift_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cap_i  (cap_w),
    .load_i (load_w),
    .word_i (tx_word_i),
    .bit_o  (bit_w)
  );

  txser_outsel outsel_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .bit_i   (bit_w),
    .loop_i  (loop_en_i),
    .ser_a_o (ser_a_o),
    .ser_b_o (ser_b_o),
    .wrap_o  (wrap_o)
  );
endmodule

// File: rtl/txser_checker.sv
module txser_checker
  import txser_pkg::*;
#(
  parameter int WORD_W = TXSER_WORD_W
) (
  input logic clk_i,
  input logic rst_i,
  input logic loop_en_i,
  input logic byte_clk_o,
  input logic ser_a_o,
  input logic ser_b_o,
  input logic wrap_o
);
  localparam int CNT_W = phase_bits(WORD_W) + 1;

  logic             bc_q;
  logic             seen_q;
  logic [CNT_W-1:0] gap_q;
  logic             rise_w;

  assign rise_w = byte_clk_o & ~bc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bc_q   <= 1'b1;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      bc_q   <= byte_clk_o;
      seen_q <= seen_q | rise_w;
      gap_q  <= rise_w ? '0 : gap_q + 1'b1;
    end
  end

  AST_BYTE_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_w && seen_q) |-> (gap_q == CNT_W'(WORD_W - 1))); // R2

  AST_MIRROR_AB: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(loop_en_i) |-> (ser_a_o == ser_b_o)); // R4

  AST_LOOP_PARK: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(loop_en_i) |-> (ser_a_o && ser_b_o)); // R5

  AST_WRAP_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(loop_en_i) |-> wrap_o); // R6

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (ser_a_o && ser_b_o && wrap_o)); // R8
endmodule

bind txser_top txser_checker #(.WORD_W(WORD_W)) checker_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .loop_en_i  (loop_en_i),
  .byte_clk_o (byte_clk_o),
  .ser_a_o    (ser_a_o),
  .ser_b_o    (ser_b_o),
  .wrap_o     (wrap_o)
);

// File: tb/txser_top_tb_top.sv
`timescale 1ns/1ps
module txser_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] tx_word;
  logic       loop_en;
  logic       byte_clk, ser_a, ser_b, wrap;

  int errors = 0;
  int checks = 0;
  logic [9:0] cur;

  always #2 clk = ~clk;

  txser_top dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .tx_word_i  (tx_word),
    .loop_en_i  (loop_en),
    .byte_clk_o (byte_clk),
    .ser_a_o    (ser_a),
    .ser_b_o    (ser_b),
    .wrap_o     (wrap)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Precondition: at the falling edge just after the capture of cur.
  task automatic send(input logic [9:0] next_w, input logic lp, input string tag);
    loop_en = lp;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) tx_word = next_w;
      chk(ser_a == (lp ? 1'b1 : cur[k]), {tag, " R1 R3 R5 R7 ser_a"}, ser_a, lp ? 1 : cur[k]);
      chk(ser_b == ser_a, {tag, " R4 ser_b"}, ser_b, ser_a);
      chk(wrap == (lp ? cur[k] : 1'b1), {tag, " R6 wrap"}, wrap, lp ? cur[k] : 1);
      chk(byte_clk == (k <= 3 || k == 9), {tag, " R2 byte_clk"}, byte_clk, (k <= 3 || k == 9));
    end
    cur = next_w;
  endtask

  task automatic t_reset();
    rst = 1'b1; loop_en = 1'b0; tx_word = 10'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ser_a && ser_b && wrap, "R8 reset outputs", {ser_a, ser_b, wrap}, 3'b111);
    chk(byte_clk == 1'b1, "R2 reset byte_clk", byte_clk, 1);
    rst = 1'b0;
  endtask

  // Counts edges from reset release to the first capture; R7 latency and R8 idle.
  task automatic t_idle(input logic [9:0] w0);
    tx_word = w0;
    for (int i = 1; i <= 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(ser_a && ser_b && wrap, "R8 R7 idle before first bit", {ser_a, ser_b, wrap}, 3'b111);
      chk(byte_clk == (i < 5 || i == 10), "R2 first rise at edge 10", byte_clk, (i < 5 || i == 10));
    end
    cur = w0;
  endtask

  task automatic t_normal();
    send(10'h2AA, 1'b0, "normal");
    send(10'h0F3, 1'b0, "normal");
    send(10'h155, 1'b0, "normal");
  endtask

  task automatic t_loopback();
    send(10'h2C1, 1'b1, "loopback");
    send(10'h17C, 1'b1, "loopback");
  endtask

  task automatic t_resume();
    send(10'h000, 1'b0, "resume");
  endtask

  task automatic t_extremes();
    send(10'h3FF, 1'b0, "R9 zeros");
    send(10'h000, 1'b0, "R9 ones");
    send(10'h000, 1'b1, "R9 zeros wrapped");
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle(10'h17C);
    t_normal();
    t_loopback();
    t_resume();
    t_extremes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule